// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplex and Clear

This block keeps a vector of single-bit outputs and updates one bit at a time. A binary select picks the target bit and a single data line supplies its value. Two active-low controls, a write enable and a clear, choose among four modes:

| Write enable (`en_n_i`) | Clear (`clr_n_i`) | Mode |
|---|---|---|
| low | high | addressable write |
| high | high | hold |
| low | low | one-hot demultiplexer |
| high | low | clear-all |

It serves as a bank of individually settable control flags, or as a decoder that steers one data line to one of several outputs.

The parameter `CLOCKED` picks one of two storage styles. With `CLOCKED = 1` the controls are sampled on the rising clock edge. With `CLOCKED = 0` the storage is level-sensitive, and the addressed bit follows the data line while the write enable is low. In both styles `rst_n` clears every bit at once, without waiting for a clock edge.

All pins are plain control and data levels. There is no handshake, and every input is acted on in every cycle. The select must only change while the write enable is high.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low, every bit of `q_o` is 0, with no clock edge needed.
- R2: When `en_n_i`=0 and `clr_n_i`=1, output bit `q_o[sel_i]` takes the value of `data_i`.
- R3: When `en_n_i` returns high, the addressed bit keeps the data value it last took, even if `data_i` then changes.
- R4: In addressable-write mode, every bit other than `q_o[sel_i]` keeps its previous value.
- R5: When `en_n_i`=1 and `clr_n_i`=1, all output bits keep their values, whatever `data_i` and `sel_i` do.
- R6: When `en_n_i`=1 and `clr_n_i`=0, all output bits become 0.
- R7: When `en_n_i`=0 and `clr_n_i`=0, `q_o[sel_i]` equals `data_i` and every other bit is 0.
- R8: `sel_i` is read as an unsigned binary index, with `sel_i[SEL_W-1]` as the most significant bit. Value k selects `q_o[k]`, so `sel_i`=3'b101 selects `q_o[5]`.
- R9: With `CLOCKED`=1, `q_o` changes only on a rising edge of `clk`, using the inputs sampled at that edge. With `CLOCKED`=0, `q_o` follows the mode table without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (used only when `CLOCKED`=1) |
| rst_n | input | 1 | Asynchronous active-low reset; clears all bits |
| data_i | input | 1 | Value written to the addressed bit |
| sel_i | input | SEL_W | Binary index of the target bit |
| en_n_i | input | 1 | Active-low write enable |
| clr_n_i | input | 1 | Active-low clear |
| q_o | output | 2**SEL_W | Stored bit vector |

## Verification
The bench builds the block twice with `SEL_W`=3: once with `CLOCKED`=1 and once with `CLOCKED`=0. Both copies receive the same stimulus and are compared against one bench model of the eight bits. Running them side by side shows that the level-sensitive copy settles before the clock edge while the clocked copy is still showing its old value. It also exercises all eight select values in every mode, including select changes made while writing is disabled.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alatch_mode_e;

  function automatic alatch_mode_e mode_of(input logic en_n, input logic clr_n);
    case ({en_n, clr_n})
      2'b01:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DEMUX;
      default: return MODE_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/alatch_ctrl.sv
module alatch_ctrl
  import alatch_pkg::*;
(
  input  logic en_n_i,
  input  logic clr_n_i,
  output logic wr_o,
  output logic zero_all_o,
  output logic zero_rest_o
);

  alatch_mode_e mode;

  always_comb begin
    mode        = mode_of(en_n_i, clr_n_i);
    wr_o        = 1'b0;
    zero_all_o  = 1'b0;
    zero_rest_o = 1'b0;
    unique case (mode)
      MODE_WRITE: wr_o = 1'b1;
      MODE_DEMUX: begin
        wr_o        = 1'b1;
        zero_rest_o = 1'b1;
      end
      MODE_CLEAR: zero_all_o = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/alatch_sel_dec.sv
module alatch_sel_dec #(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [NBITS-1:0] hit_o
);

  for (genvar k = 0; k < NBITS; k++) begin : g_hit
    assign hit_o[k] = (sel_i == SEL_W'(k));
  end

endmodule

// File: rtl/alatch_cell.sv
module alatch_cell #(
  parameter bit CLOCKED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic zero_i,
  input  logic d_i,
  output logic q_o
);

  if (CLOCKED) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (load_i) q_o <= d_i;
      else if (zero_i) q_o <= 1'b0;
    end

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (q_o == $past(d_i)));

    // R6
    zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_i && !load_i) |=> !q_o);

    // R5
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !zero_i) |=> $stable(q_o));
  end else begin : g_latch
    always_latch begin
      if (!rst_n)      q_o <= 1'b0;
      else if (load_i) q_o <= d_i;
      else if (zero_i) q_o <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int SEL_W   = 3,
  parameter bit CLOCKED = 1'b1,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_n_i,
  input  logic             clr_n_i,
  output logic [NBITS-1:0] q_o
);

  logic             wr;
  logic             zero_all;
  logic             zero_rest;
  logic [NBITS-1:0] hit;

  alatch_ctrl u_ctrl (
    .en_n_i      (en_n_i),
    .clr_n_i     (clr_n_i),
    .wr_o        (wr),
    .zero_all_o  (zero_all),
    .zero_rest_o (zero_rest)
  );

  alatch_sel_dec #(.SEL_W(SEL_W)) u_dec (
    .sel_i (sel_i),
    .hit_o (hit)
  );

  for (genvar k = 0; k < NBITS; k++) begin : g_bit
    logic load;
    logic zero;
    assign load = wr & hit[k];
    assign zero = zero_all | (zero_rest & ~hit[k]);

    alatch_cell #(.CLOCKED(CLOCKED)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .zero_i (zero),
      .d_i    (data_i),
      .q_o    (q_o[k])
    );
  end

  if (CLOCKED) begin : g_chk
    // R6
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n_i && !clr_n_i) |=> (q_o == '0));

    // R7
    demux_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n_i && !clr_n_i) |=>
        (q_o == (NBITS'($past(data_i)) << $past(sel_i))));
  end

endmodule

// File: tb/addr_latch8_bench.sv
module addr_latch8_bench;

  localparam int SEL_W = 3;
  localparam int NB    = 1 << SEL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic en_n = 1'b1;
  logic clr_n = 1'b1;
  logic [NB-1:0] q_clk;
  logic [NB-1:0] q_lvl;
  logic [NB-1:0] model = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_latch8 #(.SEL_W(SEL_W), .CLOCKED(1'b1)) u_addr_latch8 (
    .clk(clk), .rst_n(rst_n), .data_i(data), .sel_i(sel),
    .en_n_i(en_n), .clr_n_i(clr_n), .q_o(q_clk));

  addr_latch8 #(.SEL_W(SEL_W), .CLOCKED(1'b0)) u_addr_latch8_lvl (
    .clk(clk), .rst_n(rst_n), .data_i(data), .sel_i(sel),
    .en_n_i(en_n), .clr_n_i(clr_n), .q_o(q_lvl));

  function automatic logic [NB-1:0] next_q(input logic [NB-1:0] q, input logic d,
      input logic [SEL_W-1:0] s, input logic en_b, input logic clr_b);
    logic [NB-1:0] r;
    r = q;
    if (en_b && !clr_b) r = '0;
    else if (!en_b) begin
      if (!clr_b) r = '0;
      r[s] = d;
    end
    return r;
  endfunction

  task automatic chk(input logic [NB-1:0] act, input logic [NB-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic [SEL_W-1:0] s, input logic en_b,
      input logic clr_b, input string tag);
    logic [NB-1:0] nxt;
    @(negedge clk);
    data = d; sel = s; en_n = en_b; clr_n = clr_b;
    nxt = next_q(model, d, s, en_b, clr_b);
    #1;
    chk(q_lvl, nxt, {tag, " level"});
    chk(q_clk, model, "R9 before edge");
    @(posedge clk); #1;
    chk(q_clk, nxt, {tag, " clocked"});
    model = nxt;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic pd, pen;
    logic [SEL_W-1:0] ps;
    repeat (3) @(posedge clk);
    #1;
    chk(q_clk, '0, "R1 reset clocked");
    chk(q_lvl, '0, "R1 reset level");
    @(negedge clk); rst_n = 1'b1;

    // R8, R2, R4, R3: walk every index, set odd ones
    for (int i = 0; i < NB; i++) begin
      step(1'b0, SEL_W'(i), 1'b1, 1'b1, "R5");
      step(i[0], SEL_W'(i), 1'b0, 1'b1, "R2");
      step(i[0], SEL_W'(i), 1'b1, 1'b1, "R3");
    end
    chk(q_clk, 8'hAA, "R8 pattern");
    // R3: data changes after enable rises
    step(1'b1, 3'd2, 1'b1, 1'b1, "R5");
    step(1'b1, 3'd2, 1'b0, 1'b1, "R2");
    step(1'b1, 3'd2, 1'b1, 1'b1, "R3");
    step(1'b0, 3'd2, 1'b1, 1'b1, "R3");
    chk(q_lvl, 8'hAE, "R4 others kept");
    // R5: hold while inputs wander
    for (int i = 0; i < 6; i++) step(i[0], SEL_W'(7 - i), 1'b1, 1'b1, "R5");
    // R6
    step(1'b1, 3'd1, 1'b1, 1'b0, "R6");
    chk(q_clk, '0, "R6 all zero");
    // R7 demux
    step(1'b1, 3'd5, 1'b1, 1'b1, "R5");
    step(1'b1, 3'd5, 1'b0, 1'b0, "R7");
    chk(q_lvl, 8'h20, "R7 one hot");
    step(1'b0, 3'd5, 1'b0, 1'b0, "R7");
    step(1'b1, 3'd5, 1'b0, 1'b0, "R7");
    step(1'b1, 3'd5, 1'b0, 1'b1, "R2");
    step(1'b1, 3'd5, 1'b1, 1'b1, "R3");

    // constrained random: select moves only while enable stays high
    void'($urandom(32'h5EED_0259));
    for (int n = 0; n < 600; n++) begin
      logic d, eb, cb;
      logic [SEL_W-1:0] s;
      pd = data; ps = sel; pen = en_n;
      eb = ($urandom % 3) != 0;
      cb = ($urandom % 5) != 0;
      d  = 1'($urandom);
      s  = SEL_W'($urandom);
      if (!pen || !eb) s = ps;
      if (!pen && eb) d = pd;
      step(d, s, eb, cb, eb ? (cb ? "R5" : "R6") : (cb ? "R4" : "R7"));
    end

    // R1: asynchronous reset mid-run
    step(1'b1, sel, 1'b0, 1'b1, "R2");
    @(negedge clk); rst_n = 1'b0; #1;
    chk(q_clk, '0, "R1 async clocked");
    chk(q_lvl, '0, "R1 async level");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule